// File: doc/BRIEF.md
# Burst Column Address Generator

This block supplies the column address for every beat of a memory burst in a synchronous DRAM device. A start pulse loads a column, a three-bit length code, an ordering choice (linear wrap or XOR) and the direction of the access. From the following cycle on, the block presents one column per enabled clock until the burst runs out, a stop request arrives or a fresh start replaces it.

A clock-enable input freezes all progress for any cycle in which it is low. A write may be shortened to a single beat by a mode bit. A page-long linear burst continues around the whole page until it is stopped or restarted. Unsupported settings fall back to a one-beat burst and raise an error flag. Data storage and command decoding are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `last_beat` is high only in the final beat, and `beat_valid` drops on the next enabled cycle unless a new start is taken.
- R2: With `intlv` = 0 (linear order), the low log2(length) bits count up by one from the start value and wrap inside the aligned block. A 4-beat burst from 2 gives 2, 3, 0, 1.
- R3: With `intlv` = 1 (XOR order), beat k carries the start value XOR k in its low bits. An 8-beat burst from 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R4: Column bits above the length field keep their start values for the whole burst.
- R5: Code 3'b111 with `intlv` = 0 gives a page burst. It steps through all 2^COL_W columns, wraps at the page end and keeps going. It never raises `last_beat` and ends only on stop or a new start.
- R6: `stop` sampled high with `cke` high and `start` low ends the burst. `beat_valid` is low from the next cycle on.
- R7: A cycle with `cke` low leaves the column, the beat position and every output unchanged, and `start` and `stop` are ignored in that cycle.
- R8: `start` is taken in any enabled cycle, including during a burst. The first beat of the new burst follows in the next cycle with no gap.
- R9: When `single_wr` = 1, a write start (`is_write` = 1) runs exactly one beat whatever the code. Read starts keep the programmed length.
- R10: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `intlv` = 1, run a one-beat burst and set `config_error`. `config_error` stays set until the next accepted start, which reloads it.
- R11: After reset, `beat_valid`, `last_beat` and `config_error` are low.
- R12: After a start sampled with `cke` high, the next cycle shows `beat_valid` = 1 with `col` equal to the start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| start | input | 1 | Load a new burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| intlv | input | 1 | 0 linear order, 1 XOR order |
| is_write | input | 1 | The starting burst is a write |
| single_wr | input | 1 | Force write bursts to one beat |
| stop | input | 1 | End the running burst |
| col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is present this cycle |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| config_error | output | 1 | Last start used an unsupported setting |

## Verification
The hardest situation to reach is a page burst that crosses the page end while the clock enable drops, followed by a start or stop that arrives in the same cycle as a final beat or a frozen cycle. Directed runs let a page burst pass its wrap point with the enable toggling. Restarts are placed exactly on final beats. A long random phase then mixes starts, stops and enable gaps at rates chosen so that these collisions occur many times. A behavioural model rebuilds the expected column from the start value and a beat count, and it is compared every cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;

  localparam logic [2:0] LEN_ONE  = 3'b000;
  localparam logic [2:0] LEN_TWO  = 3'b001;
  localparam logic [2:0] LEN_FOUR = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;
endpackage

// File: rtl/bcg_rst_sync.sv
module bcg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code,
  input  order_e           order,
  input  logic             force_one,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page_mode,
  output logic             bad_cfg
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic [COL_W-1:0] code_mask;
  logic             code_page;

  always_comb begin
    code_mask = '0;
    code_page = 1'b0;
    bad_cfg   = 1'b0;
    unique case (len_code)
      LEN_ONE:   code_mask = '0;
      LEN_TWO:   code_mask = COL_W'(1);
      LEN_FOUR:  code_mask = COL_W'(3);
      LEN_EIGHT: code_mask = COL_W'(7);
      LEN_PAGE: begin
        if (order == ORD_LINEAR) code_page = 1'b1;
        else                     bad_cfg   = 1'b1;
      end
      default:   bad_cfg = 1'b1;
    endcase
  end

  always_comb begin
    if (force_one) begin
      wrap_mask = '0;
      page_mode = 1'b0;
    end else if (code_page) begin
      wrap_mask = ALL_ONES;
      page_mode = 1'b1;
    end else begin
      wrap_mask = code_mask;
      page_mode = 1'b0;
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] wrap_mask,
  input  order_e           order,
  output logic [COL_W-1:0] col_out
);
  logic [COL_W-1:0] linear_col;
  logic [COL_W-1:0] xor_col;
  logic [COL_W-1:0] mixed;

  assign linear_col = base_col + beat_idx;
  assign xor_col    = base_col ^ beat_idx;
  assign mixed      = (order == ORD_XOR) ? xor_col : linear_col;

  generate
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign col_out[b] = wrap_mask[b] ? mixed[b] : base_col[b];
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             intlv,
  input  logic             is_write,
  input  logic             single_wr,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             last_beat,
  output logic             config_error
);
  logic rst_q_n;

  logic             active_q, active_d;
  logic [COL_W-1:0] base_q,   base_d;
  logic [COL_W-1:0] idx_q,    idx_d;
  logic [COL_W-1:0] mask_q,   mask_d;
  logic             page_q,   page_d;
  logic             err_q,    err_d;
  order_e           ord_q,    ord_d;

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_err;
  logic             final_beat;
  order_e           in_order;

  assign in_order = intlv ? ORD_XOR : ORD_LINEAR;

  bcg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  bcg_cfg_decode #(.COL_W(COL_W)) u_dec (
    .len_code  (len_code),
    .order     (in_order),
    .force_one (is_write & single_wr),
    .wrap_mask (dec_mask),
    .page_mode (dec_page),
    .bad_cfg   (dec_err)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base_col  (base_q),
    .beat_idx  (idx_q),
    .wrap_mask (mask_q),
    .order     (ord_q),
    .col_out   (col)
  );

  assign final_beat = active_q & ~page_q & (idx_q == mask_q);

  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    idx_d    = idx_q;
    mask_d   = mask_q;
    page_d   = page_q;
    err_d    = err_q;
    ord_d    = ord_q;
    if (cke) begin
      if (start) begin
        active_d = 1'b1;
        base_d   = start_col;
        idx_d    = '0;
        mask_d   = dec_mask;
        page_d   = dec_page;
        err_d    = dec_err;
        ord_d    = in_order;
      end else if (active_q) begin
        if (stop || final_beat) active_d = 1'b0;
        else                    idx_d    = idx_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      page_q   <= 1'b0;
      err_q    <= 1'b0;
      ord_q    <= ORD_LINEAR;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      idx_q    <= idx_d;
      mask_q   <= mask_d;
      page_q   <= page_d;
      err_q    <= err_d;
      ord_q    <= ord_d;
    end
  end

  assign beat_valid   = active_q;
  assign last_beat    = final_beat;
  assign config_error = err_q;

  a_r1_last_in_valid: assert property (@(posedge clk) disable iff (!rst_q_n)
    last_beat |-> beat_valid);
  a_r1_last_ends: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cke && last_beat && !start) |=> !beat_valid);
  a_r5_page_runs: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cke && beat_valid && page_q && !stop) |=> beat_valid);
  a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cke && stop && !start) |=> !beat_valid);
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cke |=> ($stable(col) && $stable(beat_valid) && $stable(last_beat)));
  a_r12_first_beat: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cke && start) |=> (beat_valid && col == $past(start_col)));
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cke && start && is_write && single_wr) |=> last_beat);
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cke && start && len_code == 3'b100) |=> (config_error && last_beat));
endmodule

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;
  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cke = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             intlv = 1'b0;
  logic             is_write = 1'b0;
  logic             single_wr = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col;
  logic             beat_valid, last_beat, config_error;

  burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .start_col(start_col),
    .len_code(len_code), .intlv(intlv), .is_write(is_write),
    .single_wr(single_wr), .stop(stop), .col(col), .beat_valid(beat_valid),
    .last_beat(last_beat), .config_error(config_error)
  );

  always #2 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string tag = "R11";

  // behavioural model
  bit m_act = 0;
  int m_base = 0;
  int m_k = 0;
  int m_len = 1;
  bit m_page = 0;
  bit m_xor = 0;
  bit m_err = 0;

  function automatic int exp_col();
    int span, low;
    span = m_page ? PAGE : m_len;
    if (m_xor) return m_base ^ m_k;
    low = m_base % span;
    return m_base - low + ((low + m_k) % span);
  endfunction

  function automatic bit exp_last();
    return m_act && !m_page && (m_k == m_len - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_err = 0;
    end else if (cke) begin
      if (start) begin
        m_act = 1; m_base = start_col; m_k = 0; m_xor = intlv;
        m_page = 0; m_err = 0;
        case (len_code)
          3'd0: m_len = 1;
          3'd1: m_len = 2;
          3'd2: m_len = 4;
          3'd3: m_len = 8;
          3'd7: if (intlv) begin m_len = 1; m_err = 1; end
                else begin m_len = 1; m_page = 1; end
          default: begin m_len = 1; m_err = 1; end
        endcase
        if (is_write && single_wr) begin m_len = 1; m_page = 0; end
      end else if (m_act) begin
        if (stop || exp_last()) m_act = 0;
        else m_k = m_page ? (m_k + 1) % PAGE : m_k + 1;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check("beat_valid", beat_valid, m_act);
    check("last_beat", last_beat, exp_last());
    check("config_error", config_error, m_err);
    if (m_act) check("col", col, exp_col());
  end

  task automatic idle(int n);
    start = 0; stop = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic go(int c, int code, bit x, bit wr, bit sw);
    start = 1; start_col = COL_W'(c); len_code = 3'(code);
    intlv = x; is_write = wr; single_wr = sw;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);

    tag = "R1";
    for (int c = 0; c < 4; c++) begin go(0, c, 0, 0, 0); idle(10); end
    tag = "R2";
    go(2, 2, 0, 0, 0); idle(6);
    go(13, 3, 0, 0, 0); idle(10);
    tag = "R4";
    go(8'hA6, 3, 0, 0, 0); idle(10);
    go(8'hF3, 2, 1, 0, 0); idle(6);
    tag = "R3";
    go(5, 3, 1, 0, 0); idle(10);
    go(8'h37, 2, 1, 0, 0); idle(6);
    tag = "R5";
    go(8'hFE, 7, 0, 0, 0); idle(PAGE + 20);
    tag = "R6";
    stop = 1; @(negedge clk); stop = 0; idle(3);
    go(1, 3, 0, 0, 0); idle(3); stop = 1; @(negedge clk); stop = 0; idle(6);
    tag = "R7";
    go(6, 3, 1, 0, 0);
    for (int i = 0; i < 20; i++) begin
      cke = (i % 3 != 1);
      start = (i == 7); stop = (i == 10);
      @(negedge clk);
    end
    cke = 1; idle(4);
    go(8'hFD, 7, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin cke = i[0]; @(negedge clk); end
    cke = 1; stop = 1; @(negedge clk); stop = 0; idle(3);
    tag = "R8";
    go(0, 3, 0, 0, 0); idle(2); go(4, 2, 1, 0, 0); go(9, 1, 0, 0, 0);
    idle(1); go(20, 2, 0, 0, 0); idle(3); go(40, 2, 0, 0, 0); idle(6);
    tag = "R9";
    go(3, 3, 0, 1, 1); idle(4);
    go(3, 3, 0, 0, 1); idle(10);
    go(3, 7, 0, 1, 1); idle(4);
    tag = "R10";
    for (int c = 4; c < 7; c++) begin go(c * 9, c, 0, 0, 0); idle(3); end
    go(17, 7, 1, 0, 0); idle(3);
    go(17, 1, 0, 0, 0); idle(4);
    tag = "R12";
    for (int i = 0; i < 3000; i++) begin
      start = ($urandom % 6 == 0);
      start_col = COL_W'($urandom);
      len_code = 3'($urandom);
      intlv = 1'($urandom); is_write = 1'($urandom); single_wr = 1'($urandom);
      cke = ($urandom % 5 != 0);
      stop = ($urandom % 12 == 0);
      @(negedge clk);
    end
    cke = 1; idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule